// File: doc/BRIEF.md
# Multi-Device Stream Start Trigger

This block holds back a channel's sample stream until a start event arrives on a trigger line shared by several devices. Software arms it through an 8-bit control register; while armed, the gate output stays low and the sample path is stalled. One device on the line is the master. It drives the line when software sets its fire bit, and it counts its own fire as the start event in that same cycle. Every other device is a slave. A slave treats the line as an input and starts on a rising edge of that line.

The line sits on a bidirectional pin, presented here as separate input, output and output-enable signals. After the start event the gate stays open until software clears the arm bit. Arming again from the disarmed state closes the gate until the next event.

Control register fields:
- bit 0: arm.
- bit 1: fire.
- bit 2: role, where 1 means master.
- bit 3: line level, read-only.
- bits 7 to 4: reserved, always read as 0.

A write takes effect at the clock edge that samples it. The read port is a register that reflects the state after each edge.

Top module: `stream_start_trigger`

## Requirements
- R1: After reset, `reg_rd_data` is 0x00, `stream_gate` is 1, and `trig_line_oe` and `trig_line_out` are 0.
- R2: While bit 0 (arm) reads 0, `stream_gate` is 1, whatever the line does.
- R3: Writing arm=1 from the disarmed state drives `stream_gate` low at the edge that samples the write.
- R4: On a master, a write with bit 0, bit 1 and bit 2 all 1 has three effects at the sampling edge: `trig_line_out` goes to 1, bit 1 and bit 3 read 1, and `stream_gate` goes to 1. If the write has arm=0, fire has no effect.
- R5: A write with bit 1 set and bit 2 clear (slave) leaves `trig_line_out` at 0, leaves bit 1 reading 0 and leaves the gate closed.
- R6: `trig_line_oe` equals the role bit (bit 2) written last. Switching the role to slave drops the fire state and the driven line.
- R7: Bit 3 reads the driven value on a master and the synchronised input on a slave. Writes to bit 3 are ignored. On a master, the input pin never triggers.
- R8: Bits 7 to 4 always read 0, whatever is written to them.
- R9: An armed slave opens the gate on a rising edge of the line after a two-flop synchroniser. The gate rises on the third edge after the input rises. A line that is already high when arming happens is not an event.
- R10: Once open, the gate stays open through any line activity until arm is cleared. Arming again closes it.
- R11: The fire state and `trig_line_out` stay at 1 through later writes that keep arm=1, and clear when arm is written 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write value |
| reg_rd_data | output | 8 | Registered control register read value |
| trig_line_in | input | 1 | Trigger pin input (asynchronous) |
| trig_line_out | output | 1 | Trigger pin output value |
| trig_line_oe | output | 1 | Trigger pin output enable (master) |
| stream_gate | output | 1 | 1 lets samples flow, 0 stalls them |

## Verification
An arm write from the disarmed state and a synchronised rising edge on a slave's line can land on the same clock edge. In that case the design must count the edge and open the gate at once rather than lose it. The bench sets this up by raising the input two cycles ahead, so that the synchroniser's edge falls on the cycle that samples the arm write. It then expects the gate to read 1 and bit 3 to read 1 after that edge. A second case in the same spirit puts a disarm and a line edge together and expects the gate to remain open without any latched trigger.

// File: rtl/strig_pkg.sv
package strig_pkg;
  localparam int CTRL_W   = 8;
  localparam int BIT_ARM  = 0;
  localparam int BIT_FIRE = 1;
  localparam int BIT_MSTR = 2;
  localparam int BIT_LINE = 3;

  typedef struct packed {
    logic master;
    logic fire;
    logic arm;
  } ctrl_t;
endpackage

// File: rtl/strig_sync.sv
module strig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign rise  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/strig_ctrl_regs.sv
module strig_ctrl_regs
  import strig_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_n
);
  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_en) begin
      ctrl_n.arm    = wr_data[BIT_ARM];
      ctrl_n.master = wr_data[BIT_MSTR];
      // fire is a pulse on write, held while armed master
      ctrl_n.fire   = wr_data[BIT_ARM] & wr_data[BIT_MSTR]
                    & (wr_data[BIT_FIRE] | ctrl_q.fire);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_n;
  end
endmodule

// File: rtl/strig_gate.sv
module strig_gate
  import strig_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl_n,
  input  logic  line_rise,
  output logic  gate_q
);
  logic hit_q;
  logic hit_n;
  logic event_n;

  always_comb begin
    event_n = ctrl_n.master ? ctrl_n.fire : line_rise;
    hit_n   = ctrl_n.arm & (hit_q | event_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q  <= 1'b0;
      gate_q <= 1'b1;
    end else begin
      hit_q  <= hit_n;
      gate_q <= ~ctrl_n.arm | hit_n;
    end
  end
endmodule

// File: rtl/stream_start_trigger.sv
module stream_start_trigger
  import strig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [CTRL_W-1:0] reg_wr_data,
  output logic [CTRL_W-1:0] reg_rd_data,
  input  logic              trig_line_in,
  output logic              trig_line_out,
  output logic              trig_line_oe,
  output logic              stream_gate
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_n;
  logic  line_lvl;
  logic  line_rise;
  logic  rd_line;

  strig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .din   (trig_line_in),
    .level (line_lvl),
    .rise  (line_rise)
  );

  strig_ctrl_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .ctrl_q  (ctrl_q),
    .ctrl_n  (ctrl_n)
  );

  strig_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .ctrl_n    (ctrl_n),
    .line_rise (line_rise),
    .gate_q    (stream_gate)
  );

  assign rd_line = ctrl_n.master ? ctrl_n.fire : line_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_data   <= '0;
      trig_line_out <= 1'b0;
      trig_line_oe  <= 1'b0;
    end else begin
      reg_rd_data           <= '0;
      reg_rd_data[BIT_ARM]  <= ctrl_n.arm;
      reg_rd_data[BIT_FIRE] <= ctrl_n.fire;
      reg_rd_data[BIT_MSTR] <= ctrl_n.master;
      reg_rd_data[BIT_LINE] <= rd_line;
      trig_line_out         <= ctrl_n.fire;
      trig_line_oe          <= ctrl_n.master;
    end
  end
endmodule

// File: rtl/stream_start_trigger_chk.sv
module stream_start_trigger_chk (
  input logic       clk,
  input logic       rst,
  input logic       reg_wr_en,
  input logic [7:0] reg_wr_data,
  input logic [7:0] reg_rd_data,
  input logic       trig_line_out,
  input logic       trig_line_oe,
  input logic       stream_gate
);
  assert_disarmed_open_R2: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_data[0] |-> stream_gate);

  assert_fire_opens_R4: assert property (@(posedge clk) disable iff (rst)
    (trig_line_oe && trig_line_out) |-> stream_gate);

  assert_slave_fire_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !reg_wr_data[2]) |=> !trig_line_out);

  assert_oe_follows_role_R6: assert property (@(posedge clk) disable iff (rst)
    trig_line_oe == reg_rd_data[2]);

  assert_master_line_mirror_R7: assert property (@(posedge clk) disable iff (rst)
    trig_line_oe |-> (reg_rd_data[3] == trig_line_out));

  assert_line_needs_arm_R11: assert property (@(posedge clk) disable iff (rst)
    trig_line_out |-> reg_rd_data[0]);
endmodule

bind stream_start_trigger stream_start_trigger_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_wr_en     (reg_wr_en),
  .reg_wr_data   (reg_wr_data),
  .reg_rd_data   (reg_rd_data),
  .trig_line_out (trig_line_out),
  .trig_line_oe  (trig_line_oe),
  .stream_gate   (stream_gate)
);

// File: tb/stream_start_trigger_bench.sv
`timescale 1ns/1ps
module stream_start_trigger_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_data;
  logic       trig_line_in = 1'b0;
  logic       trig_line_out;
  logic       trig_line_oe;
  logic       stream_gate;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic       gate;
    logic       oe;
    logic       out;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  stream_start_trigger u_stream_start_trigger (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .trig_line_in(trig_line_in),
    .trig_line_out(trig_line_out), .trig_line_oe(trig_line_oe),
    .stream_gate(stream_gate)
  );

  // driver: one cycle per call, expectation is for the state after the next edge
  task automatic op(input logic wr, input logic [7:0] d, input logic lin,
                    input logic [7:0] e_rd, input logic e_gate,
                    input logic e_oe, input logic e_out, input string tag);
    exp_t e;
    @(negedge clk);
    reg_wr_en    = wr;
    reg_wr_data  = d;
    trig_line_in = lin;
    e.rd = e_rd; e.gate = e_gate; e.oe = e_oe; e.out = e_out; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if (reg_rd_data !== e.rd || stream_gate !== e.gate ||
            trig_line_oe !== e.oe || trig_line_out !== e.out) begin
          bad++;
          $display("FAIL %s: rd=%h gate=%b oe=%b out=%b expected rd=%h gate=%b oe=%b out=%b",
                   e.tag, reg_rd_data, stream_gate, trig_line_oe, trig_line_out,
                   e.rd, e.gate, e.oe, e.out);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    op(0, 8'h00, 0, 8'h00, 1, 0, 0, "R1 reset");
    // R8 R7: reserved and line bits ignored on write
    op(1, 8'hF8, 0, 8'h00, 1, 0, 0, "R8 reserved write");
    // R3 slave arm closes gate
    op(1, 8'h01, 0, 8'h01, 0, 0, 0, "R3 arm slave");
    // R5 fire on slave ignored
    op(1, 8'h03, 0, 8'h01, 0, 0, 0, "R5 slave fire");
    op(0, 8'h00, 0, 8'h01, 0, 0, 0, "R5 slave idle");
    // R9 slave rising edge, gate on third edge
    op(0, 8'h00, 1, 8'h01, 0, 0, 0, "R9 sync1");
    op(0, 8'h00, 1, 8'h01, 0, 0, 0, "R9 sync2");
    op(0, 8'h00, 1, 8'h09, 1, 0, 0, "R9 slave trigger");
    // R10 gate held through line fall
    op(0, 8'h00, 0, 8'h09, 1, 0, 0, "R10 hold1");
    op(0, 8'h00, 0, 8'h09, 1, 0, 0, "R10 hold2");
    op(0, 8'h00, 0, 8'h01, 1, 0, 0, "R10 hold3");
    // R10 disarm then re-arm closes
    op(1, 8'h00, 0, 8'h00, 1, 0, 0, "R2 disarm");
    op(1, 8'h01, 0, 8'h01, 0, 0, 0, "R10 rearm");
    // R9 line already high at arm time: no event; R2 edge while disarmed
    op(1, 8'h00, 1, 8'h00, 1, 0, 0, "R2 disarm high");
    op(0, 8'h00, 1, 8'h00, 1, 0, 0, "R2 sync");
    op(0, 8'h00, 1, 8'h08, 1, 0, 0, "R2 edge disarmed");
    op(1, 8'h01, 1, 8'h09, 0, 0, 0, "R9 level no edge");
    op(0, 8'h00, 0, 8'h09, 0, 0, 0, "R9 fall1");
    op(0, 8'h00, 0, 8'h09, 0, 0, 0, "R9 fall2");
    op(0, 8'h00, 0, 8'h01, 0, 0, 0, "R9 fall3");
    // same-cycle: arm write meets synchronised edge
    op(1, 8'h00, 0, 8'h00, 1, 0, 0, "R2 disarm");
    op(0, 8'h00, 1, 8'h00, 1, 0, 0, "R9 pre1");
    op(0, 8'h00, 1, 8'h00, 1, 0, 0, "R9 pre2");
    op(1, 8'h01, 1, 8'h09, 1, 0, 0, "R9 arm with edge");
    op(1, 8'h00, 0, 8'h08, 1, 0, 0, "R10 disarm");
    op(0, 8'h00, 0, 8'h08, 1, 0, 0, "R7 slave level");
    op(0, 8'h00, 0, 8'h00, 1, 0, 0, "R7 slave low");
    // master
    op(1, 8'h04, 0, 8'h04, 1, 1, 0, "R6 master role");
    op(0, 8'h00, 1, 8'h04, 1, 1, 0, "R7 master input");
    op(1, 8'h05, 1, 8'h05, 0, 1, 0, "R3 arm master");
    op(0, 8'h00, 0, 8'h05, 0, 1, 0, "R7 master ignores edge");
    op(0, 8'h00, 0, 8'h05, 0, 1, 0, "R7 master idle");
    op(1, 8'h07, 0, 8'h0F, 1, 1, 1, "R4 master fire");
    op(1, 8'h05, 0, 8'h0F, 1, 1, 1, "R11 fire held");
    op(1, 8'h04, 0, 8'h04, 1, 1, 0, "R11 fire cleared");
    op(1, 8'h05, 0, 8'h05, 0, 1, 0, "R10 master rearm");
    op(1, 8'h00, 0, 8'h00, 1, 0, 0, "R6 back to slave");
    op(1, 8'h06, 0, 8'h04, 1, 1, 0, "R4 fire needs arm");
    op(1, 8'h07, 0, 8'h0F, 1, 1, 1, "R4 fire again");
    op(1, 8'h01, 0, 8'h01, 1, 0, 0, "R6 switch to slave");
    op(0, 8'h00, 0, 8'h01, 1, 0, 0, "R6 final");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule